// File: doc/BRIEF.md
# Eight-Bit Function-Select ALU

This block is the combinational arithmetic and logic unit of a small accumulator processor. Each cycle it takes two operands, a three-bit function select and a carry-in, and returns a result word, a carry-out and a zero indication. It holds no state. The status register and the operand multiplexers belong to neighbouring blocks.

All four arithmetic selects share one adder. The select code decides what reaches the adder's second input: zero, the B operand, its inverse, or all ones. The carry-in comes from the microcode sequencer as a constant 0, a constant 1, the stored carry, or its inverse. With the constants, one select code gives two operations: transfer or increment, add or add-plus-one, subtract or subtract-minus-one, and decrement or pass. With the stored carry, a sequence of byte operations can add or subtract words wider than eight bits. The upper four select codes are bitwise logic operations, and they do not use the carry-in.

Top module: `fsel_alu`

## Requirements
- R1: Select 3'b000 returns op_a + carry_in. This is a transfer of A when carry_in is 0 and an increment of A when carry_in is 1.
- R2: Select 3'b001 returns op_a + op_b + carry_in.
- R3: Select 3'b010 returns op_a + ~op_b + carry_in. This is A − B when carry_in is 1 and A − B − 1 when carry_in is 0. carry_out is 1 when no borrow occurs.
- R4: Select 3'b011 returns op_a + 8'hFF + carry_in. This is a decrement when carry_in is 0 and a transfer of A with carry_out 1 when carry_in is 1.
- R5: The selects map to logic operations as follows: 3'b100 gives A OR B, 3'b101 gives A XOR B, 3'b110 gives A AND B and 3'b111 gives NOT A. For these four selects, carry_in has no effect on any output.
- R6: For selects 3'b000 to 3'b011, carry_out is bit 8 of the nine-bit sum. For selects 3'b100 to 3'b111, carry_out is 0.
- R7: zero_flag is 1 exactly when all eight result bits are 0, for every select code.
- R8: Feeding the carry_out of a low-byte operation into the carry_in of the high-byte operation gives correct 16-bit addition with select 3'b001 and correct 16-bit subtraction with select 3'b010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (accumulator side) |
| op_b | input | 8 | Second operand |
| func_sel | input | 3 | Function select code |
| carry_in | input | 1 | Carry into the adder, chosen by the sequencer |
| result | output | 8 | Function result |
| carry_out | output | 1 | Adder carry for arithmetic selects, 0 for logic selects |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
A table of directed vectors hits the points where operations coincide:
- increment of 8'hFF wrapping to zero with a carry;
- subtraction both with and without a borrow;
- decrement of 8'h00 and of 8'h01;
- XOR of equal operands, which gives zero.

A sweep then runs every select and carry-in pair against all 256 values of A and 18 values of B, including 0 and 8'hFF. This separates the two meanings of each arithmetic code. It also shows carry_in having no effect on the logic codes, because the same A and B are tried with both carry-in values. Two 16-bit chained operations, an add and a subtract, check that carry and borrow pass correctly from the low byte to the high byte.

// File: rtl/fsel_alu_pkg.sv
package fsel_alu_pkg;
   localparam int FN_W = 3;

   // Lower two select bits inside the arithmetic group: adder B input choice
   typedef enum logic [1:0] {
      BSRC_ZERO = 2'b00,
      BSRC_B    = 2'b01,
      BSRC_INVB = 2'b10,
      BSRC_ONES = 2'b11
   } bsrc_e;

   // Lower two select bits inside the logic group
   typedef enum logic [1:0] {
      LOP_OR  = 2'b00,
      LOP_XOR = 2'b01,
      LOP_AND = 2'b10,
      LOP_NOT = 2'b11
   } lop_e;
endpackage

// File: rtl/fsel_alu_bsel.sv
module fsel_alu_bsel
   import fsel_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] op_b,
   input  bsrc_e            src,
   output logic [WIDTH-1:0] b_eff
);
   always_comb begin
      unique case (src)
         BSRC_ZERO: b_eff = '0;
         BSRC_B:    b_eff = op_b;
         BSRC_INVB: b_eff = ~op_b;
         default:   b_eff = '1;
      endcase
   end
endmodule

// File: rtl/fsel_alu_adder.sv
module fsel_alu_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int SUM_W = WIDTH + 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign cout = cy[WIDTH];
      end else begin : g_infer
         logic [SUM_W-1:0] full;
         assign full = {1'b0, a} + {1'b0, b} + SUM_W'(cin);
         assign sum  = full[WIDTH-1:0];
         assign cout = full[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/fsel_alu_logic.sv
module fsel_alu_logic
   import fsel_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  lop_e             op,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (op)
         LOP_OR:  y = a | b;
         LOP_XOR: y = a ^ b;
         LOP_AND: y = a & b;
         default: y = ~a;
      endcase
   end
endmodule

// File: rtl/fsel_alu.sv
module fsel_alu
   import fsel_alu_pkg::*;
#(
   parameter int WIDTH         = 8,
   parameter bit RIPPLE_ADDER  = 1'b0
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [FN_W-1:0]  func_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero_flag
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fsel_alu: WIDTH must be at least 2");
      end
      if (FN_W != 3) begin : g_bad_fn
         $error("fsel_alu: select width must be 3");
      end
   endgenerate

   logic             is_logic;
   bsrc_e            bsrc;
   lop_e             lop;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;
   logic             add_cout;
   logic [WIDTH-1:0] lres;

   assign is_logic = func_sel[2];
   assign bsrc     = bsrc_e'(func_sel[1:0]);
   assign lop      = lop_e'(func_sel[1:0]);

   fsel_alu_bsel #(.WIDTH(WIDTH)) u_bsel (
      .op_b  (op_b),
      .src   (bsrc),
      .b_eff (b_eff)
   );

   fsel_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_ADDER)) u_add (
      .a    (op_a),
      .b    (b_eff),
      .cin  (carry_in),
      .sum  (sum),
      .cout (add_cout)
   );

   fsel_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a  (op_a),
      .b  (op_b),
      .op (lop),
      .y  (lres)
   );

   assign result    = is_logic ? lres : sum;
   assign carry_out = is_logic ? 1'b0 : add_cout;
   assign zero_flag = ~|result;
endmodule

// File: rtl/fsel_alu_chk.sv
module fsel_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [2:0]       func_sel,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             zero_flag
);
   logic known;
   assign known = !$isunknown({op_a, op_b, func_sel, carry_in, result, carry_out, zero_flag});

   always_comb begin
      if (known) begin
         // R1
         pass_chk: assert (!(func_sel == 3'b000 && !carry_in) || (result == op_a && !carry_out));
         // R2
         add_chk: assert (func_sel != 3'b001 ||
                          {carry_out, result} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
         // R3
         sub_chk: assert (!(func_sel == 3'b010 && carry_in) ||
                          (result == op_a - op_b && carry_out == (op_a >= op_b)));
         // R4
         dec_pass_chk: assert (!(func_sel == 3'b011 && carry_in) || (result == op_a && carry_out));
         // R6
         logic_carry_chk: assert (!func_sel[2] || !carry_out);
         // R7
         zero_chk: assert (zero_flag == (result == '0));
      end
   end
endmodule

bind fsel_alu fsel_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a      (op_a),
   .op_b      (op_b),
   .func_sel  (func_sel),
   .carry_in  (carry_in),
   .result    (result),
   .carry_out (carry_out),
   .zero_flag (zero_flag)
);

// File: tb/tb_fsel_alu.sv
module tb_fsel_alu;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] op_a, op_b, result;
   logic [2:0] func_sel;
   logic       carry_in, carry_out, zero_flag;
   int         checks = 0;
   int         errors = 0;
   int         cycles = 0;
   bit         done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fsel_alu dut (
      .op_a(op_a), .op_b(op_b), .func_sel(func_sel), .carry_in(carry_in),
      .result(result), .carry_out(carry_out), .zero_flag(zero_flag)
   );

   // {a, b, sel, cin, exp_result, exp_carry, exp_zero}
   localparam int NV = 15;
   localparam logic [29:0] VEC [NV] = '{
      {8'h5A, 8'hFF, 3'd0, 1'b0, 8'h5A, 1'b0, 1'b0},  // R1 transfer
      {8'hFF, 8'h00, 3'd0, 1'b1, 8'h00, 1'b1, 1'b1},  // R1 increment wrap
      {8'h3C, 8'hC4, 3'd1, 1'b0, 8'h00, 1'b1, 1'b1},  // R2 add to 0x100
      {8'h10, 8'h20, 3'd1, 1'b1, 8'h31, 1'b0, 1'b0},  // R2 add plus one
      {8'h50, 8'h30, 3'd2, 1'b1, 8'h20, 1'b1, 1'b0},  // R3 no borrow
      {8'h30, 8'h50, 3'd2, 1'b1, 8'hE0, 1'b0, 1'b0},  // R3 borrow
      {8'h50, 8'h30, 3'd2, 1'b0, 8'h1F, 1'b1, 1'b0},  // R3 minus one
      {8'h01, 8'h77, 3'd3, 1'b0, 8'h00, 1'b1, 1'b1},  // R4 decrement to zero
      {8'h00, 8'h77, 3'd3, 1'b0, 8'hFF, 1'b0, 1'b0},  // R4 decrement wrap
      {8'h7E, 8'h00, 3'd3, 1'b1, 8'h7E, 1'b1, 1'b0},  // R4 pass with carry
      {8'hF0, 8'h0F, 3'd4, 1'b1, 8'hFF, 1'b0, 1'b0},  // R5 OR
      {8'hAA, 8'hAA, 3'd5, 1'b1, 8'h00, 1'b0, 1'b1},  // R5 XOR -> zero
      {8'hCC, 8'hAA, 3'd6, 1'b1, 8'h88, 1'b0, 1'b0},  // R5 AND
      {8'h00, 8'h5A, 3'd7, 1'b0, 8'hFF, 1'b0, 1'b0},  // R5 NOT
      {8'hFF, 8'h5A, 3'd7, 1'b1, 8'h00, 1'b0, 1'b1}   // R5 NOT -> zero
   };

   function automatic logic [9:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                          input logic [2:0] s, input logic ci);
      int unsigned t;
      logic [7:0]  r;
      logic        c;
      t = 0; r = '0; c = 1'b0;
      case (s)
         3'd0: t = a + ci;
         3'd1: t = a + b + ci;
         3'd2: t = a + (255 - b) + ci;
         3'd3: t = a + 255 + ci;
         3'd4: r = a | b;
         3'd5: r = a ^ b;
         3'd6: r = a & b;
         default: r = ~a;
      endcase
      if (s < 3'd4) begin
         r = t[7:0];
         c = t[8];
      end
      return {(r == 8'h00), c, r};
   endfunction

   function automatic string req_of(input logic [2:0] s);
      case (s)
         3'd0: return "R1/R6/R7";
         3'd1: return "R2/R6/R7";
         3'd2: return "R3/R6/R7";
         3'd3: return "R4/R6/R7";
         default: return "R5/R6/R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: a=%02h b=%02h sel=%0d cin=%0b got {z,c,r}=%03h expected %03h",
                  req, op_a, op_b, func_sel, carry_in, got, exp);
      end
   endtask

   task automatic drive(input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] s, input logic ci);
      op_a = a; op_b = b; func_sel = s; carry_in = ci;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, cycles=%0d expected < 150000", cycles);
         finish_run();
      end
   end

   initial begin
      logic [7:0] lo_r;
      logic       lo_c;
      drive(8'h00, 8'h00, 3'd0, 1'b0);
      repeat (3) @(negedge clk);
      // R7 idle state: zero operands, transfer select
      check("R7 idle", {zero_flag, carry_out, result}, {1'b1, 1'b0, 8'h00});
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][29:22], VEC[i][21:14], VEC[i][13:11], VEC[i][10]);
         check({"table ", req_of(VEC[i][13:11])}, {zero_flag, carry_out, result},
               {VEC[i][0], VEC[i][1], VEC[i][9:2]});
      end

      // Sweep: every select and carry pair, all A, spread of B
      for (int s = 0; s < 8; s++) begin
         for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 256; a++) begin
               for (int bi = 0; bi < 18; bi++) begin
                  drive(8'(a), 8'(bi * 15), 3'(s), 1'(ci));
                  check({"sweep ", req_of(3'(s))}, {zero_flag, carry_out, result},
                        ref_alu(8'(a), 8'(bi * 15), 3'(s), 1'(ci)));
               end
            end
         end
      end

      // R5: carry_in ignored for logic selects, same operands both carry values
      for (int s = 4; s < 8; s++) begin
         drive(8'h96, 8'h3C, 3'(s), 1'b0);
         lo_r = result;
         drive(8'h96, 8'h3C, 3'(s), 1'b1);
         check("R5 cin ignored", {zero_flag, carry_out, result}, {lo_r == 8'h00, 1'b0, lo_r});
      end

      // R8: 16-bit add 0x12F0 + 0x0E30 = 0x2120
      drive(8'hF0, 8'h30, 3'd1, 1'b0);
      lo_r = result; lo_c = carry_out;
      drive(8'h12, 8'h0E, 3'd1, lo_c);
      check("R8 add16", {1'b0, carry_out, result, lo_r}, {1'b0, 1'b0, 16'h2120});

      // R8: 16-bit subtract 0x2000 - 0x0001 = 0x1FFF
      drive(8'h00, 8'h01, 3'd2, 1'b1);
      lo_r = result; lo_c = carry_out;
      drive(8'h20, 8'h00, 3'd2, lo_c);
      check("R8 sub16", {1'b0, carry_out, result, lo_r}, {1'b0, 1'b1, 16'h1FFF});

      @(negedge clk);
      finish_run();
   end
endmodule